// File: doc/BRIEF.md
# Pulse-Margin Byte Programming Sequencer

This controller writes one byte into a memory whose cells can only be cleared from 1 to 0. On a start strobe it captures a target address and byte. It then applies program pulses of one millisecond each. After every pulse it reads the cell back through a verify bus. A pulse is one assertion of the program strobe with address and data held steady.

When the read-back equals the target, the controller applies one over-program pulse. That pulse is `OVER_MULT` times longer than an initial pulse for each initial pulse that was needed, so a byte that was slow to program gets a proportionally larger margin. A final verify then decides between the done and fail outcomes. If the byte still does not verify after `MAX_PULSES` initial pulses, the controller gives up and applies no over-program pulse.

Time is counted in clock ticks. `TICKS_PER_MS` sets how many ticks make one millisecond, so a test can shrink it. Switching of the programming voltage and stepping through many addresses belong to the surrounding system.

Top module: `prog_pulse_seq`

## Requirements
- R1: After reset, prog_pulse, verify_en, done, fail and busy are 0, pulse_count is 0, and prog_addr and prog_data are 0.
- R2: Each initial program pulse keeps prog_pulse high for exactly TICKS_PER_MS consecutive cycles. The first pulse begins in the cycle after start is sampled high in an idle, done or fail state.
- R3: After every pulse, verify_en is high for exactly one cycle, and prog_pulse is low in that cycle. verify_data is compared with the target byte in that cycle.
- R4: When an initial-pulse verify matches, the next pulse is an over-program pulse lasting OVER_MULT × n × TICKS_PER_MS cycles, where n is the number of initial pulses applied.
- R5: When an initial-pulse verify mismatches and n is below MAX_PULSES, another initial pulse follows in the next cycle.
- R6: When the verify after the MAX_PULSES-th initial pulse mismatches, fail rises with pulse_count equal to MAX_PULSES, and no over-program pulse is applied.
- R7: When the verify after the over-program pulse mismatches, fail rises and done stays low.
- R8: When the verify after the over-program pulse matches, done rises. done and fail are never high together, and each holds until the next accepted start.
- R9: A start strobe while busy is high is ignored: the address, data, pulse count and timing of the running operation are unchanged.
- R10: pulse_count equals the number of initial pulses completed in the current operation, and it is cleared when a start is accepted. prog_addr and prog_data show the address and byte captured at start for the whole operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin programming the presented byte |
| addr_in | input | ADDR_W | Target address captured at start |
| data_in | input | DATA_W | Target byte captured at start |
| verify_data | input | DATA_W | Read-back of the cell, valid while verify_en is high |
| prog_addr | output | ADDR_W | Latched address driven to the memory |
| prog_data | output | DATA_W | Latched byte driven to the memory |
| prog_pulse | output | 1 | Program strobe, high during a pulse |
| verify_en | output | 1 | Read-back request, one cycle per verify |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | Byte programmed and verified with margin |
| fail | output | 1 | Byte could not be programmed |
| pulse_count | output | CNT_W | Initial pulses applied so far |

## Verification
A behavioural cell model answers verify reads with the target byte only once a chosen number of pulses has been applied. Runs that settle after one pulse and after several pulses show whether the over-program length follows n rather than being fixed. A cell that never settles reaches the pulse cap and checks that no over-program pulse is emitted. A cell that loses its value after the over-program pulse separates the final-verify decision from the initial one. An all-ones byte, and a second start issued in the middle of a run, cover the trivial-match and ignored-strobe cases.

// File: rtl/prog_pulse_seq.sv
module prog_pulse_seq #(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int TICKS_PER_MS = 1000,
  parameter int MAX_PULSES   = 25,
  parameter int OVER_MULT    = 3,
  localparam int CNT_W       = $clog2(MAX_PULSES + 1),
  localparam int TW          = $clog2(OVER_MULT * MAX_PULSES * TICKS_PER_MS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] verify_data,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              prog_pulse,
  output logic              verify_en,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  pulse_count
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PULSE, ST_CHECK, ST_OVER, ST_FCHECK, ST_DONE, ST_FAIL
  } st_t;

  st_t             st;
  logic [TW-1:0]   timer;
  logic [CNT_W-1:0] n;

  localparam logic [TW-1:0] ONE_MS  = TW'(TICKS_PER_MS - 1);
  localparam logic [TW-1:0] OVER_MS = TW'(OVER_MULT * TICKS_PER_MS);

  wire match    = (verify_data == prog_data);
  wire idle_ish = (st == ST_IDLE) || (st == ST_DONE) || (st == ST_FAIL);
  wire tdone    = (timer == '0);

  assign prog_pulse  = (st == ST_PULSE) || (st == ST_OVER);
  assign verify_en   = (st == ST_CHECK) || (st == ST_FCHECK);
  assign busy        = !idle_ish;
  assign done        = (st == ST_DONE);
  assign fail        = (st == ST_FAIL);
  assign pulse_count = n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      timer     <= '0;
      n         <= '0;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      unique case (st)
        ST_IDLE, ST_DONE, ST_FAIL: begin
          if (start) begin
            prog_addr <= addr_in;
            prog_data <= data_in;
            n         <= '0;
            timer     <= ONE_MS;
            st        <= ST_PULSE;
          end
        end
        ST_PULSE: begin
          if (tdone) begin
            n  <= n + 1'b1;
            st <= ST_CHECK;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        ST_CHECK: begin
          if (match) begin
            timer <= OVER_MS * TW'(n) - 1'b1;
            st    <= ST_OVER;
          end else if (n >= CNT_W'(MAX_PULSES)) begin
            st <= ST_FAIL;
          end else begin
            timer <= ONE_MS;
            st    <= ST_PULSE;
          end
        end
        ST_OVER: begin
          if (tdone) st <= ST_FCHECK;
          else       timer <= timer - 1'b1;
        end
        ST_FCHECK: st <= match ? ST_DONE : ST_FAIL;
        default:   st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/prog_pulse_seq_chk.sv
module prog_pulse_seq_chk #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int MAX_PULSES = 25,
  parameter int CNT_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [DATA_W-1:0] prog_data,
  input logic              prog_pulse,
  input logic              verify_en,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [CNT_W-1:0]  pulse_count
);

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_pulse && verify_en));

  p_verify_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    verify_en |=> !verify_en);

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  p_count_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_count <= CNT_W'(MAX_PULSES));

  p_done_from_verify_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(verify_en));

  p_fail_from_verify_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(verify_en));

  p_target_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(prog_data) && $stable(prog_addr)));

endmodule

bind prog_pulse_seq prog_pulse_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_PULSES(MAX_PULSES), .CNT_W(CNT_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr), .prog_data(prog_data),
  .prog_pulse(prog_pulse), .verify_en(verify_en), .busy(busy),
  .done(done), .fail(fail), .pulse_count(pulse_count)
);

// File: tb/test_prog_pulse_seq.sv
module test_prog_pulse_seq;
  localparam int AW = 15, DW = 8, T = 4, MAXP = 25, OM = 3;
  localparam int CW = $clog2(MAXP + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] verify_data;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic prog_pulse, verify_en, busy, done, fail;
  logic [CW-1:0] pulse_count;

  int checks = 0, errors = 0, cycles = 0;

  prog_pulse_seq #(.ADDR_W(AW), .DATA_W(DW), .TICKS_PER_MS(T),
                   .MAX_PULSES(MAXP), .OVER_MULT(OM)) i_prog_pulse_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in),
    .data_in(data_in), .verify_data(verify_data), .prog_addr(prog_addr),
    .prog_data(prog_data), .prog_pulse(prog_pulse), .verify_en(verify_en),
    .busy(busy), .done(done), .fail(fail), .pulse_count(pulse_count));

  always #2 clk = ~clk;

  // cell model
  int need = 1;
  bit corrupt = 0;
  logic [DW-1:0] target = '0;
  int npul = 0, cur_w = 0, nver = 0;
  int widths [32];
  bit prev_pp = 0;

  always_comb
    verify_data = (npul >= need && !(corrupt && npul > need)) ? target : '1;

  always @(negedge clk) begin
    cycles++;
    if (verify_en) nver++;
    if (prog_pulse) cur_w++;
    if (prev_pp && !prog_pulse) begin
      if (npul < 32) widths[npul] = cur_w;
      npul++;
      cur_w = 0;
    end
    prev_pp = prog_pulse;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int k, input bit corr, input bit restart,
                          input int exp_n, input bit exp_done, input bit exp_over);
    int waitc;
    @(negedge clk);
    need = k; corrupt = corr; target = d & 8'hFF;
    npul = 0; cur_w = 0; nver = 0;
    addr_in = a; data_in = d; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy && pulse_count == 0, "R10 count cleared on start", int'(pulse_count), 0);
    if (restart) begin
      repeat (2) @(negedge clk);
      addr_in = ~a; data_in = ~d; start = 1;   // R9: ignored while busy
      @(negedge clk);
      start = 0;
    end
    waitc = 0;
    while (!(done || fail) && waitc < 5000) begin
      @(negedge clk);
      waitc++;
    end
    chk(done == exp_done, "R8 done outcome", int'(done), int'(exp_done));
    chk(fail == !exp_done, "R6/R7 fail outcome", int'(fail), int'(!exp_done));
    chk(int'(pulse_count) == exp_n, "R10 pulse_count", int'(pulse_count), exp_n);
    chk(npul == exp_n + (exp_over ? 1 : 0), "R5/R6 number of pulses", npul,
        exp_n + (exp_over ? 1 : 0));
    chk(nver == npul, "R3 one verify per pulse", nver, npul);
    for (int i = 0; i < exp_n && i < 32; i++)
      chk(widths[i] == T, "R2 initial pulse width", widths[i], T);
    if (exp_over)
      chk(widths[exp_n] == OM * exp_n * T, "R4 over-program width",
          widths[exp_n], OM * exp_n * T);
    chk(prog_data == d && prog_addr == a, "R9/R10 target held", int'(prog_data), int'(d));
    repeat (3) @(negedge clk);
    chk(done == exp_done && fail == !exp_done, "R8 outcome held",
        int'({done, fail}), int'({exp_done, !exp_done}));
  endtask

  task automatic test_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!prog_pulse && !verify_en && !done && !fail && !busy, "R1 reset controls",
        int'({prog_pulse, verify_en, done, fail, busy}), 0);
    chk(pulse_count == 0 && prog_addr == 0 && prog_data == 0, "R1 reset data",
        int'(prog_data), 0);
    rst_n = 1;
  endtask

  initial begin
    test_reset();
    run_case(15'h0123, 8'hA5, 1, 0, 0, 1, 1, 1);    // R4 single pulse
    run_case(15'h7FFF, 8'h3C, 4, 0, 0, 4, 1, 1);    // R4 R5 several pulses
    run_case(15'h0042, 8'hFF, 0, 0, 0, 1, 1, 1);    // all-ones still pulses once
    run_case(15'h1000, 8'h00, 99, 0, 0, MAXP, 0, 0); // R6 cap reached
    run_case(15'h2222, 8'h5A, 2, 1, 0, 2, 0, 1);    // R7 final verify lost
    run_case(15'h0ABC, 8'h81, 3, 0, 1, 3, 1, 1);    // R9 start while busy
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule